// File: doc/BRIEF.md
# Grouped Context Match Comparator

This block decides which hardware threads a notification should reach. A notification names a target line made of a 4-bit block and a 24-bit index. Each of several thread slots holds a valid bit, a 28-bit context word and a group-eligibility bit. The block compares the target line with every slot's context word and returns a one-hot-or-more vector of matching slots, together with a flag that is set when any slot matched.

Two request flags widen the comparison. The group flag drops the low index bits from the comparison. The crowd flag drops the low block bits. In each case the number of bits dropped follows from the run of ones at the bottom of that field. The index and block masks are built separately and then joined into one line mask. When either flag is set, only slots marked group-eligible may match. One block pattern asks for a crowd of eight threads. That size is not supported, so the block raises an error flag and keeps the full block mask.

A request is a single-cycle strobe with the target and flags. Its results come out, registered, on the next clock edge with a result strobe. The block does not choose between matching threads.

Top module: `gcm_top`

## Requirements
- R1: The target line is {block[3:0], index[23:0]}, with the block in bits 27:24 of a context word. With both flags clear, a valid slot matches only when its context word equals the target line exactly.
- R2: With the group flag set, the index mask clears bit 0 up to and including the lowest zero bit of the index. An index ending in binary 0 frees 1 bit, and one ending in 01 frees 2 bits. An index of all ones frees all 24 bits.
- R3: With the crowd flag set, the block mask clears the low bits in the same way. A block ending in binary 0 frees 1 bit, and one ending in 01 frees 2 bits. A block ending in 0111, or equal to 1111, frees all 4 block bits.
- R4: With the crowd flag set and a block whose low three bits are 011, crowdErr is 1 in the result cycle and the full block must still match. In every other result cycle, crowdErr is 0.
- R5: When either flag is set, a slot whose eligibility bit is 0 never matches. When both flags are clear, the eligibility bit has no effect.
- R6: A slot whose valid bit is 0 never matches.
- R7: anyMatch is 1 exactly when at least one bit of matchVec is 1.
- R8: rspValid, matchVec, anyMatch and crowdErr show the result for a request on the clock edge after the one that sampled reqValid. In a cycle with no result, all four outputs are 0.
- R9: While rstN is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| reqBlock | input | 4 | Target block field |
| reqIndex | input | 24 | Target index field |
| reqGroup | input | 1 | Group flag: mask low index bits |
| reqCrowd | input | 1 | Crowd flag: mask low block bits |
| slotValid | input | NUM_SLOTS | Per-slot valid bits |
| slotCtx | input | NUM_SLOTS*28 | Per-slot context words, slot s at bits s*28 +: 28 |
| slotElig | input | NUM_SLOTS | Per-slot group-eligibility bits |
| rspValid | output | 1 | Result strobe |
| matchVec | output | NUM_SLOTS | Matching slots |
| anyMatch | output | 1 | At least one slot matched |
| crowdErr | output | 1 | Unsupported crowd size requested |

## Verification
Every output has a latency of exactly one edge. The reference model samples the request and slot inputs at a rising edge. It predicts rspValid, matchVec, anyMatch and crowdErr for the state the design registers at that same edge. The bench compares all four outputs at the following falling edge, so every cycle is checked, including idle cycles and cycles under reset. Inputs change only on falling edges, so the sampled values are stable when the edge arrives.

// File: rtl/gcm_pkg.sv
package gcm_pkg;
  localparam int BLK_W = 4;
  localparam int IDX_W = 24;
  localparam int LINE_W = BLK_W + IDX_W;
  // trailing-ones run that selects the unsupported crowd size of eight
  localparam int BAD_CROWD_RUN = 3;

  typedef struct packed {
    logic load;        // a request is being evaluated this cycle
    logic idxWide;     // apply the group mask to the index
    logic blkWide;     // apply the crowd mask to the block
    logic blkIllegal;  // crowd size unsupported: keep full block mask
    logic needElig;    // restrict matching to eligible slots
  } gcmStrobe_t;
endpackage

// File: rtl/gcm_ctrl.sv
module gcm_ctrl
  import gcm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqGroup,
  input  logic             reqCrowd,
  input  logic [BLK_W-1:0] reqBlock,
  output gcmStrobe_t       strobe,
  output logic             rspValid,
  output logic             crowdErr
);
  localparam logic [BLK_W-1:0] BAD_RUN_PATTERN = BLK_W'((1 << BAD_CROWD_RUN) - 1);

  logic [BLK_W-1:0] blkRun;
  logic             badCrowd;

  // mask of the trailing ones plus the first zero above them
  assign blkRun   = reqBlock ^ (reqBlock + BLK_W'(1));
  assign badCrowd = reqCrowd && (blkRun == BAD_RUN_PATTERN);

  always_comb begin
    strobe.load       = reqValid;
    strobe.idxWide    = reqGroup;
    strobe.blkWide    = reqCrowd;
    strobe.blkIllegal = badCrowd;
    strobe.needElig   = reqGroup || reqCrowd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      crowdErr <= 1'b0;
    end else begin
      rspValid <= reqValid;
      crowdErr <= reqValid && badCrowd;
    end
  end
endmodule

// File: rtl/gcm_datapath.sv
module gcm_datapath
  import gcm_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  gcmStrobe_t                  strobe,
  input  logic [BLK_W-1:0]            reqBlock,
  input  logic [IDX_W-1:0]            reqIndex,
  input  logic [NUM_SLOTS-1:0]        slotValid,
  input  logic [NUM_SLOTS*LINE_W-1:0] slotCtx,
  input  logic [NUM_SLOTS-1:0]        slotElig,
  output logic [NUM_SLOTS-1:0]        matchVec,
  output logic                        anyMatch
);
  logic [IDX_W-1:0]     idxClear;
  logic [BLK_W-1:0]     blkClear;
  logic [IDX_W-1:0]     idxMask;
  logic [BLK_W-1:0]     blkMask;
  logic [LINE_W-1:0]    lineMask;
  logic [LINE_W-1:0]    targetLine;
  logic [NUM_SLOTS-1:0] hit;

  assign idxClear   = reqIndex ^ (reqIndex + IDX_W'(1));
  assign blkClear   = reqBlock ^ (reqBlock + BLK_W'(1));
  assign idxMask    = strobe.idxWide ? ~idxClear : '1;
  assign blkMask    = (strobe.blkWide && !strobe.blkIllegal) ? ~blkClear : '1;
  assign lineMask   = {blkMask, idxMask};
  assign targetLine = {reqBlock, reqIndex};

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [LINE_W-1:0] diff;
    assign diff   = (slotCtx[s*LINE_W +: LINE_W] ^ targetLine) & lineMask;
    assign hit[s] = slotValid[s] && (!strobe.needElig || slotElig[s]) && (diff == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchVec <= '0;
      anyMatch <= 1'b0;
    end else begin
      matchVec <= strobe.load ? hit : '0;
      anyMatch <= strobe.load && (|hit);
    end
  end
endmodule

// File: rtl/gcm_top.sv
module gcm_top
  import gcm_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [BLK_W-1:0]            reqBlock,
  input  logic [IDX_W-1:0]            reqIndex,
  input  logic                        reqGroup,
  input  logic                        reqCrowd,
  input  logic [NUM_SLOTS-1:0]        slotValid,
  input  logic [NUM_SLOTS*LINE_W-1:0] slotCtx,
  input  logic [NUM_SLOTS-1:0]        slotElig,
  output logic                        rspValid,
  output logic [NUM_SLOTS-1:0]        matchVec,
  output logic                        anyMatch,
  output logic                        crowdErr
);
  gcmStrobe_t strobe;

  gcm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqGroup (reqGroup),
    .reqCrowd (reqCrowd),
    .reqBlock (reqBlock),
    .strobe   (strobe),
    .rspValid (rspValid),
    .crowdErr (crowdErr)
  );

  gcm_datapath #(.NUM_SLOTS(NUM_SLOTS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqBlock  (reqBlock),
    .reqIndex  (reqIndex),
    .slotValid (slotValid),
    .slotCtx   (slotCtx),
    .slotElig  (slotElig),
    .matchVec  (matchVec),
    .anyMatch  (anyMatch)
  );
endmodule

// File: rtl/gcm_checker.sv
module gcm_checker
  import gcm_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        reqValid,
  input logic [BLK_W-1:0]            reqBlock,
  input logic [IDX_W-1:0]            reqIndex,
  input logic                        reqGroup,
  input logic                        reqCrowd,
  input logic [NUM_SLOTS-1:0]        slotValid,
  input logic [NUM_SLOTS*LINE_W-1:0] slotCtx,
  input logic [NUM_SLOTS-1:0]        slotElig,
  input logic                        rspValid,
  input logic [NUM_SLOTS-1:0]        matchVec,
  input logic                        anyMatch,
  input logic                        crowdErr
);
  p_rsp_after_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (matchVec == '0 && !anyMatch && !crowdErr));

  p_invalid_never_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((matchVec & ~$past(slotValid)) == '0));

  p_elig_filter_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && ($past(reqGroup) || $past(reqCrowd))) |-> ((matchVec & ~$past(slotElig)) == '0));

  p_crowd_err_src_r4: assert property (@(posedge clk) disable iff (!rstN)
    crowdErr |-> ($past(reqCrowd) && $past(reqValid)));

  p_any_vs_vec_r7: assert property (@(posedge clk) disable iff (!rstN)
    anyMatch == (matchVec != '0));

  p_exact_slot0_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqGroup && !reqCrowd && slotValid[0] &&
     slotCtx[LINE_W-1:0] == {reqBlock, reqIndex}) |=> matchVec[0]);
endmodule

bind gcm_top gcm_checker #(.NUM_SLOTS(NUM_SLOTS)) u_gcm_checker (.*);

// File: tb/gcm_top_bench.sv
module gcm_top_bench;
  localparam int NS = 4;
  localparam int LW = 28;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [3:0]    reqBlock = '0;
  logic [23:0]   reqIndex = '0;
  logic          reqGroup = 1'b0;
  logic          reqCrowd = 1'b0;
  logic [NS-1:0] slotValid = '0;
  logic [NS*LW-1:0] slotCtx = '0;
  logic [NS-1:0] slotElig = '0;
  logic          rspValid;
  logic [NS-1:0] matchVec;
  logic          anyMatch;
  logic          crowdErr;

  int vectors = 0;
  int miscompares = 0;
  bit started = 0;
  bit done = 0;
  string curTag = "R8";
  string expTag = "R9";
  logic          expRsp = 1'b0;
  logic [NS-1:0] expVec = '0;
  logic          expAny = 1'b0;
  logic          expErr = 1'b0;

  always #2 clk = ~clk;

  gcm_top #(.NUM_SLOTS(NS)) u_gcm_top (.*);

  // behavioural reference: count trailing ones, derive freed bit counts
  function automatic int trailOnes(input logic [31:0] v, input int w);
    int n = 0;
    while (n < w && v[n]) n++;
    return n;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (!rstN) begin
      expRsp = 0; expVec = '0; expAny = 0; expErr = 0; expTag = "R9";
    end else begin
      int idxFree, blkFree, run;
      bit bad;
      expTag = curTag;
      expRsp = reqValid;
      expVec = '0;
      idxFree = 0; blkFree = 0; bad = 0;
      if (reqGroup) begin
        idxFree = trailOnes({8'b0, reqIndex}, 24) + 1;
        if (idxFree > 24) idxFree = 24;
      end
      if (reqCrowd) begin
        run = trailOnes({28'b0, reqBlock}, 4);
        if (run == 2) bad = 1;
        else blkFree = (run >= 3) ? 4 : run + 1;
      end
      expErr = reqValid && bad;
      if (reqValid) begin
        for (int s = 0; s < NS; s++) begin
          bit ok;
          logic [27:0] w;
          w = slotCtx[s*LW +: LW];
          ok = slotValid[s];
          if ((reqGroup || reqCrowd) && !slotElig[s]) ok = 0;
          for (int b = 0; b < 24; b++)
            if (b >= idxFree && w[b] != reqIndex[b]) ok = 0;
          for (int b = 0; b < 4; b++)
            if (b >= blkFree && w[24+b] != reqBlock[b]) ok = 0;
          expVec[s] = ok;
        end
      end
      expAny = (expVec != '0);
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      if (rspValid !== expRsp || matchVec !== expVec || anyMatch !== expAny || crowdErr !== expErr) begin
        miscompares++;
        $display("FAIL %s: got rsp=%b vec=%b any=%b err=%b, expected rsp=%b vec=%b any=%b err=%b",
                 expTag, rspValid, matchVec, anyMatch, crowdErr, expRsp, expVec, expAny, expErr);
      end
    end
  end

  task automatic setSlot(input int s, input bit v, input logic [27:0] w, input bit e);
    slotValid[s] = v;
    slotCtx[s*LW +: LW] = w;
    slotElig[s] = e;
  endtask

  task automatic req(input string tag, input logic [3:0] b, input logic [23:0] i,
                     input bit g, input bit c);
    @(negedge clk);
    curTag = tag; reqValid = 1; reqBlock = b; reqIndex = i; reqGroup = g; reqCrowd = c;
    @(negedge clk);
    reqValid = 0; curTag = "R8";
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    setSlot(0, 1, {4'h5, 24'h000100}, 1);
    setSlot(1, 1, {4'h5, 24'h000101}, 1);
    setSlot(2, 1, {4'h4, 24'h000102}, 0);
    setSlot(3, 1, {4'h7, 24'h0001FF}, 1);
    repeat (3) @(negedge clk);          // R9 reset state checked here
    rstN = 1;
    repeat (2) @(negedge clk);
    req("R1", 4'h5, 24'h000100, 0, 0);  // exact slot 0
    req("R1", 4'h5, 24'h000101, 0, 0);  // exact slot 1
    req("R1", 4'h5, 24'h000102, 0, 0);  // block differs: none
    req("R5", 4'h4, 24'h000102, 0, 0);  // ineligible slot, flags clear: matches
    req("R2", 4'h5, 24'h000100, 1, 0);  // ends 0: frees 1 bit -> slots 0,1
    req("R2", 4'h5, 24'h000101, 1, 0);  // ends 01: frees 2 bits
    req("R2", 4'h5, 24'h000103, 1, 0);  // ends 011: frees 3 bits
    req("R2", 4'hF, 24'hFFFFFF, 1, 0);  // all ones: whole index freed
    req("R2", 4'h7, 24'hFFFFFF, 1, 0);  // all ones with block 7
    req("R5", 4'h4, 24'h000102, 1, 0);  // ineligible excluded
    req("R3", 4'h4, 24'h000100, 0, 1);  // block ends 0 -> 4/5 both
    req("R3", 4'h5, 24'h000101, 1, 1);  // block ends 01
    req("R3", 4'h7, 24'h000100, 1, 1);  // 0111 frees all block bits
    req("R3", 4'hF, 24'h0001FF, 0, 1);  // 1111 frees all block bits
    req("R4", 4'h3, 24'h000100, 1, 1);  // illegal crowd size, full block
    req("R4", 4'h7, 24'h0001FF, 0, 0);  // no crowd: no error
    setSlot(0, 0, {4'h5, 24'h000100}, 1);
    req("R6", 4'h5, 24'h000100, 0, 0);  // invalid slot never matches
    req("R6", 4'h5, 24'h000100, 1, 0);
    setSlot(0, 1, {4'h5, 24'h000100}, 1);
    // back-to-back requests
    @(negedge clk);
    curTag = "R8"; reqValid = 1; reqBlock = 4'h5; reqIndex = 24'h000100; reqGroup = 0; reqCrowd = 0;
    @(negedge clk);
    reqIndex = 24'h000101;
    @(negedge clk);
    reqValid = 0;
    // mixed patterns around the slot contents
    for (int n = 0; n < 400; n++) begin
      int s;
      logic [27:0] base;
      s = int'($urandom_range(NS - 1, 0));
      base = slotCtx[s*LW +: LW] ^ {2'b0, 2'($urandom), 21'b0, 3'($urandom)};
      if (n % 50 == 0) setSlot(int'($urandom_range(NS - 1, 0)), 1'($urandom), 28'($urandom), 1'($urandom));
      @(negedge clk);
      curTag = "R7";
      reqValid = 1'($urandom); reqBlock = base[27:24]; reqIndex = base[23:0];
      reqGroup = 1'($urandom); reqCrowd = 1'($urandom);
    end
    @(negedge clk);
    reqValid = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule